// File: doc/BRIEF.md
# Inverting Open-Drain Parallel Port

This block is a sixteen-line bidirectional digital port whose lines are driven by open-drain, inverting drivers. Software stores one bit per line through two byte-wide write strobes, one for lines 7..0 and one for lines 15..8. A stored 1 turns the line's driver on and pulls the pin low. A stored 0 turns the driver off, so an external pull-up brings the line high and the line can serve as an input. There is no separate direction register: a line is an input whenever its stored bit is 0.

Every pin passes through a two-flop synchroniser. The read value is the inverted, synchronised pin level, so a low pin reads 1 and a high pin reads 0. One line, chosen by a parameter, also feeds an edge detector. A configuration input selects whether only rising edges count, or both rising and falling edges. A qualifying edge sets a pending flag. The flag drives a level interrupt request and stays set until software writes an acknowledge.

Top module: `ioport_par`

## Requirements
- R1: While reset is asserted and right after it, every output enable is 0 and `irq_req` is 0. With all pins high, `rd_data` reads 0x0000 once reset has been released.
- R2: A cycle with `wr_lo` high loads `wr_data` into `pad_oe[7:0]`. A cycle with `wr_hi` high loads `wr_data` into `pad_oe[15:8]`. The new value is visible after that clock edge. A lane that is not strobed keeps its value.
- R3: `pad_out` is 0x0000 at all times, so a line is either pulled low or released.
- R4: `rd_data[i]` equals the inverse of `pad_in[i]` as it stood two rising clock edges earlier.
- R5: A line whose stored bit is 1 reads back 1, because its own driver holds the pin low.
- R6: With `edge_any` = 0, only a low-to-high transition of the synchronised level of line `IRQ_LINE` (default 0) sets the pending flag. Falling edges, and edges on any other line, leave it unchanged.
- R7: With `edge_any` = 1, both rising and falling transitions of line `IRQ_LINE` set the pending flag.
- R8: An `irq_ack` cycle clears the pending flag at the next edge. If a qualifying edge is seen in the same cycle as the acknowledge, the flag stays set.
- R9: `irq_req` is the pending flag itself. It becomes 1 after the third rising clock edge that follows the pin change.
- R10: Once set, the pending flag stays set until an acknowledge arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_lo | input | 1 | Write strobe for lines 7..0 |
| wr_hi | input | 1 | Write strobe for lines 15..8 |
| wr_data | input | 8 | Byte written by either strobe |
| irq_ack | input | 1 | Clears the pending flag |
| edge_any | input | 1 | 0: rising edges only; 1: both edges |
| pad_in | input | 16 | Pin levels as seen at the pads |
| pad_oe | output | 16 | Driver enable per line; 1 pulls the pin low |
| pad_out | output | 16 | Value driven when enabled, fixed 0 |
| rd_data | output | 16 | Inverted, synchronised pin levels |
| irq_req | output | 1 | Level interrupt request, equal to the pending flag |

## Verification
A corrupted byte register shows up on `pad_oe` at the very next clock edge. Two edges later it also shows up on `rd_data`, because the pins loop back through the bench's pull-up model. A fault in a synchroniser stage shows up as a wrong value, or wrong timing, in the `rd_data` sample taken exactly two edges after a pin change. A broken edge detector or pending register shows up on `irq_req` at the third edge after the change on the interrupt line: it either stays low, or it rises for an edge that should not count. Acknowledge faults appear one edge after `irq_ack`.

// File: rtl/ioport_pkg.sv
package ioport_pkg;
  localparam int unsigned LANE_W = 8;

  typedef enum logic {
    EDGE_RISE_ONLY = 1'b0,
    EDGE_ANY       = 1'b1
  } edge_mode_e;

  // rising edge of the pin level always counts; falling edge only in EDGE_ANY
  function automatic logic edge_qualifies(input logic prev_lvl,
                                          input logic cur_lvl,
                                          input edge_mode_e mode);
    logic rise;
    logic fall;
    rise = !prev_lvl && cur_lvl;
    fall = prev_lvl && !cur_lvl;
    return rise || ((mode == EDGE_ANY) && fall);
  endfunction

  // a new event has priority over an acknowledge in the same cycle
  function automatic logic next_pending(input logic pend,
                                        input logic hit,
                                        input logic ack);
    logic nxt;
    if (hit)      nxt = 1'b1;
    else if (ack) nxt = 1'b0;
    else          nxt = pend;
    return nxt;
  endfunction

  // read value is the inverse of the pin level
  function automatic logic [2*LANE_W-1:0] invert_level(input logic [2*LANE_W-1:0] lvl);
    return ~lvl;
  endfunction
endpackage

// File: rtl/ioport_latch.sv
module ioport_latch #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANES-1:0]  lane_we,
  input  logic [LANE_W-1:0] wr_data,
  output logic [W-1:0]      q
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          q[g*LANE_W +: LANE_W] <= '0;
      else if (lane_we[g]) q[g*LANE_W +: LANE_W] <= wr_data;
    end
  end
endmodule

// File: rtl/ioport_sync.sv
module ioport_sync #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  // reset to all ones: released lines float high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '1;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ioport_irq.sv
module ioport_irq
  import ioport_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lvl,
  input  edge_mode_e mode,
  input  logic       ack,
  output logic       pending,
  output logic       rise_o,
  output logic       fall_o,
  output logic       hit_o
);
  logic prev_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_lvl <= 1'b1;
    else        prev_lvl <= lvl;
  end

  assign rise_o = !prev_lvl && lvl;
  assign fall_o = prev_lvl && !lvl;
  assign hit_o  = edge_qualifies(prev_lvl, lvl, mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending <= 1'b0;
    else        pending <= next_pending(pending, hit_o, ack);
  end
endmodule

// File: rtl/ioport_par.sv
module ioport_par
  import ioport_pkg::*;
#(
  parameter int unsigned IRQ_LINE    = 0,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [7:0]  wr_data,
  input  logic        irq_ack,
  input  logic        edge_any,
  input  logic [15:0] pad_in,
  output logic [15:0] pad_oe,
  output logic [15:0] pad_out,
  output logic [15:0] rd_data,
  output logic        irq_req
);
  localparam int unsigned LANES = 2;
  localparam int unsigned LINES = LANES * LANE_W;

  logic [LINES-1:0] pin_sync;
  logic             evt_rise;
  logic             evt_fall;
  logic             evt_hit;
  logic             pend;

  ioport_latch #(.LANES(LANES), .LANE_W(LANE_W)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .lane_we ({wr_hi, wr_lo}),
    .wr_data (wr_data),
    .q       (pad_oe)
  );

  ioport_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (pin_sync)
  );

  ioport_irq u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .lvl     (pin_sync[IRQ_LINE]),
    .mode    (edge_mode_e'(edge_any)),
    .ack     (irq_ack),
    .pending (pend),
    .rise_o  (evt_rise),
    .fall_o  (evt_fall),
    .hit_o   (evt_hit)
  );

  assign pad_out = '0;
  assign rd_data = invert_level(pin_sync);
  assign irq_req = pend;
endmodule

// File: rtl/ioport_par_chk.sv
module ioport_par_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_lo,
  input logic        wr_hi,
  input logic [7:0]  wr_data,
  input logic        irq_ack,
  input logic        edge_any,
  input logic [15:0] pad_in,
  input logic [15:0] pad_oe,
  input logic [15:0] rd_data,
  input logic        irq_req,
  input logic        evt_rise,
  input logic        evt_fall,
  input logic        evt_hit
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_IDLE: assert (pad_oe == 16'h0 && !irq_req) else $error("reset state"); // R1
    end
  end

  AST_OE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_lo && !wr_hi) |=> $stable(pad_oe)); // R2
  AST_LO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> pad_oe[7:0] == $past(wr_data)); // R2
  AST_HI_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> pad_oe[15:8] == $past(wr_data)); // R2
  AST_READ_INV: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2) |-> rd_data == ~$past(pad_in, 2)); // R4
  AST_RISE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_any && !evt_rise && !irq_req) |=> !irq_req); // R6
  AST_ANY_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_any && (evt_rise || evt_fall)) |=> irq_req); // R7
  AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !evt_hit) |=> !irq_req); // R8
  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !irq_ack) |=> irq_req); // R10
endmodule

bind ioport_par ioport_par_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_lo    (wr_lo),
  .wr_hi    (wr_hi),
  .wr_data  (wr_data),
  .irq_ack  (irq_ack),
  .edge_any (edge_any),
  .pad_in   (pad_in),
  .pad_oe   (pad_oe),
  .rd_data  (rd_data),
  .irq_req  (irq_req),
  .evt_rise (evt_rise),
  .evt_fall (evt_fall),
  .evt_hit  (evt_hit)
);

// File: tb/test_ioport_par.sv
module test_ioport_par;
  localparam int CLK_PERIOD = 10;
  localparam int IRQ_BIT    = 0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_lo = 1'b0, wr_hi = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        irq_ack = 1'b0;
  logic        edge_any = 1'b0;
  logic [15:0] ext = 16'hFFFF;
  logic [15:0] pad_in, pad_oe, pad_out, rd_data;
  logic        irq_req;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // pull-up wired with external drivers: a pin is low if anyone pulls it low
  assign pad_in = ext & ~pad_oe;

  ioport_par #(.IRQ_LINE(IRQ_BIT), .SYNC_STAGES(2)) i_ioport_par (
    .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
    .irq_ack(irq_ack), .edge_any(edge_any), .pad_in(pad_in), .pad_oe(pad_oe),
    .pad_out(pad_out), .rd_data(rd_data), .irq_req(irq_req)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_lane(input bit hi, input logic [7:0] v);
    wr_data = v; wr_lo = !hi; wr_hi = hi;
    step(1);
    wr_lo = 1'b0; wr_hi = 1'b0;
  endtask

  task automatic do_ack;
    irq_ack = 1'b1; step(1); irq_ack = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] exp_oe;
    logic [15:0] pat;
    step(3);
    chk(pad_oe == 16'h0, "R1 oe in reset", pad_oe, 16'h0);
    chk(irq_req == 1'b0, "R1 irq in reset", {15'h0, irq_req}, 16'h0);
    rst_n = 1'b1;
    step(3);
    chk(rd_data == 16'h0, "R1 read after reset", rd_data, 16'h0);
    chk(pad_out == 16'h0, "R3 drive value", pad_out, 16'h0);

    // R2 / R5 sweep of both lanes; own drive must read back
    exp_oe = 16'h0;
    for (int v = 0; v < 256; v++) begin
      wr_lane(1'b0, v[7:0]);
      exp_oe[7:0] = v[7:0];
      chk(pad_oe == exp_oe, "R2 low lane", pad_oe, exp_oe);
      step(2);
      chk(rd_data == exp_oe, "R5 own drive reads 1", rd_data, exp_oe);
    end
    for (int v = 0; v < 256; v++) begin
      wr_lane(1'b1, 8'(255 - v));
      exp_oe[15:8] = 8'(255 - v);
      chk(pad_oe == exp_oe, "R2 high lane", pad_oe, exp_oe);
      chk(pad_out == 16'h0, "R3 drive value", pad_out, 16'h0);
      step(2);
      chk(rd_data == exp_oe, "R5 own drive reads 1", rd_data, exp_oe);
    end
    wr_lane(1'b0, 8'h00);
    wr_lane(1'b1, 8'h00);
    chk(pad_oe == 16'h0, "R2 cleared", pad_oe, 16'h0);

    // R4 walking zero on external drivers, with latency check
    pat = 16'h0;
    step(3);
    for (int i = 0; i < 16; i++) begin
      ext = ~(16'h1 << i);
      step(1);
      chk(rd_data == pat, "R4 not yet visible", rd_data, pat);
      step(1);
      pat = 16'h1 << i;
      chk(rd_data == pat, "R4 inverted read", rd_data, pat);
    end
    for (int k = 1; k < 20; k++) begin
      ext = 16'(k * 16'h9E37);
      step(2);
      chk(rd_data == ~ext, "R4 pattern read", rd_data, ~ext);
    end

    // interrupts, rising-only mode
    ext = 16'hFFFF; edge_any = 1'b0;
    step(4); do_ack(); step(1);
    chk(irq_req == 1'b0, "R8 cleared before test", {15'h0, irq_req}, 16'h0);
    ext[IRQ_BIT] = 1'b0; step(5);
    chk(irq_req == 1'b0, "R6 fall ignored", {15'h0, irq_req}, 16'h0);
    ext[5] = 1'b0; step(4); ext[5] = 1'b1; step(4);
    chk(irq_req == 1'b0, "R6 other line ignored", {15'h0, irq_req}, 16'h0);
    ext[IRQ_BIT] = 1'b1; step(2);
    chk(irq_req == 1'b0, "R9 not before third edge", {15'h0, irq_req}, 16'h0);
    step(1);
    chk(irq_req == 1'b1, "R9 rise sets pending", {15'h0, irq_req}, 16'h1);
    step(6);
    chk(irq_req == 1'b1, "R10 pending held", {15'h0, irq_req}, 16'h1);
    do_ack();
    chk(irq_req == 1'b0, "R8 ack clears", {15'h0, irq_req}, 16'h0);

    // both-edges mode
    edge_any = 1'b1;
    ext[IRQ_BIT] = 1'b0; step(3);
    chk(irq_req == 1'b1, "R7 fall sets pending", {15'h0, irq_req}, 16'h1);
    do_ack(); step(2);
    chk(irq_req == 1'b0, "R8 ack clears", {15'h0, irq_req}, 16'h0);
    ext[IRQ_BIT] = 1'b1; step(3);
    chk(irq_req == 1'b1, "R7 rise sets pending", {15'h0, irq_req}, 16'h1);
    do_ack();
    // own driver on the interrupt line produces a falling edge
    wr_lane(1'b0, 8'h01); step(3);
    chk(irq_req == 1'b1, "R7 self-driven fall", {15'h0, irq_req}, 16'h1);
    do_ack(); wr_lane(1'b0, 8'h00); step(4); do_ack(); step(1);
    chk(irq_req == 1'b0, "R8 idle before collision", {15'h0, irq_req}, 16'h0);

    // acknowledge in the same cycle as a qualifying edge
    ext[IRQ_BIT] = 1'b0; step(2);
    irq_ack = 1'b1; step(1); irq_ack = 1'b0;
    chk(irq_req == 1'b1, "R8 edge beats ack", {15'h0, irq_req}, 16'h1);
    do_ack();
    chk(irq_req == 1'b0, "R8 later ack clears", {15'h0, irq_req}, 16'h0);

    finish_run();
  end
endmodule